// File: doc/BRIEF.md
# Port Reset Status Handler

This block holds the status/control registers of a set of host-controller ports and defines what a software write to one of them does. A write arrives as an index plus a 32-bit value. A value with neither reset bit set is stored as written. A value that asks for a normal or a warm reset is handled as a reset that finishes at once:

- a one-cycle reset request goes to the device-slot logic for that port;
- the stored value is rewritten to show a finished reset;
- a port-status-change event is queued, tagged with the one-based port number.

Events leave on a valid/ready output. Ports whose event cannot go out yet wait in a per-port pending bitmap. When several ports are waiting, the lowest port number is sent first. Software can read any register back through a registered read port.

Top module: `port_reset_status`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rd_data`, `evt_valid` and `slot_rst_req` are all zero. Every port register is zero.
- R2: A write whose bit 4 (normal reset) and bit 31 (warm reset) are both zero stores `wr_data` unchanged in register `wr_idx`.
- R3: A write is a reset request if bit 4 is one, if bit 31 is one, or if both are one.
- R4: A reset request stores a rewritten value. Bits 8:5 (link state) become 0, bit 4 becomes 0, bit 1 (enabled) becomes 1 and bit 21 (reset change) becomes 1. Every other bit, bit 31 included, keeps its written value.
- R5: `slot_rst_req[wr_idx]` is high for exactly the one cycle after a reset-request write. It is zero in every other cycle, and at most one bit of it is ever set.
- R6: A reset request makes an event whose `evt_port` is `wr_idx + 1`. If the output is empty or is being accepted, `evt_valid` rises in the cycle after the write.
- R7: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_port` does not change.
- R8: When the output is busy, pending events are kept one bit per port. They are issued lowest port number first, one per accepted transfer.
- R9: A reset of a port whose event is still pending, and not yet on the output, merges with that event. Only one event for that port is issued.
- R10: `rd_data` in the cycle after an edge equals the register selected by `rd_idx` as it was just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Zero-based port index of the write |
| wr_data | input | 32 | Value written |
| rd_idx | input | IDX_W | Zero-based port index to read |
| rd_data | output | 32 | Registered read data |
| slot_rst_req | output | N_PORTS | One-cycle per-port reset request to the device slots |
| evt_valid | output | 1 | Status-change event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_port | output | PID_W | One-based port number of the event |

## Verification
A write sampled at an edge is applied at that edge. `slot_rst_req` and the event are therefore due in the cycle right after the write. The rewritten register shows on `rd_data` one cycle later, because the read port adds a register. The bench drives inputs at the falling edge and compares every output there against a behavioural model that advances once per rising edge. Each result is checked exactly in the cycle it is due. The model covers both the back-pressure sequences, where events wait and merge, and the plain-write and warm-reset paths.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int REG_W   = 32;
  localparam int B_EN    = 1;
  localparam int B_RST   = 4;
  localparam int B_LS_LO = 5;
  localparam int B_LS_HI = 8;
  localparam int B_RCHG  = 21;
  localparam int B_WARM  = 31;

  function automatic logic wants_reset(input logic [REG_W-1:0] d);
    return d[B_RST] | d[B_WARM];
  endfunction

  function automatic logic [REG_W-1:0] finish_reset(input logic [REG_W-1:0] d);
    logic [REG_W-1:0] r;
    r = d;
    r[B_LS_HI:B_LS_LO] = '0;
    r[B_RST]  = 1'b0;
    r[B_EN]   = 1'b1;
    r[B_RCHG] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/prs_reg_bank.sv
module prs_reg_bank
  import prs_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [REG_W-1:0]   rd_data,
  output logic [N_PORTS-1:0] hit_vec,
  output logic [N_PORTS-1:0] slot_rst_req
);
  logic [REG_W-1:0] regs [N_PORTS];
  logic             is_rst;
  logic [REG_W-1:0] new_val;

  assign is_rst  = wants_reset(wr_data);
  assign new_val = is_rst ? finish_reset(wr_data) : wr_data;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic sel;
    assign sel        = wr_en && (wr_idx == IDX_W'(g));
    assign hit_vec[g] = sel && is_rst;

    always_ff @(posedge clk) begin
      if (rst)      regs[g] <= '0;
      else if (sel) regs[g] <= new_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      slot_rst_req <= '0;
    end else begin
      rd_data      <= (int'(rd_idx) < N_PORTS) ? regs[rd_idx] : '0;
      slot_rst_req <= hit_vec;
    end
  end
endmodule

// File: rtl/prs_evt_arb.sv
module prs_evt_arb #(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2,
  parameter int PID_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] set_vec,
  input  logic               evt_ready,
  output logic               evt_valid,
  output logic [PID_W-1:0]   evt_port
);
  logic [N_PORTS-1:0] pend;
  logic [N_PORTS-1:0] cand;
  logic [IDX_W-1:0]   pick;
  logic               any;
  logic               load;

  assign cand = pend | set_vec;
  assign load = !evt_valid || evt_ready;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick = IDX_W'(i);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      evt_valid <= 1'b0;
      evt_port  <= '0;
    end else if (load) begin
      evt_valid <= any;
      if (any) begin
        evt_port <= PID_W'(pick) + PID_W'(1);
        pend     <= cand & ~(N_PORTS'(1) << pick);
      end else begin
        pend     <= cand;
      end
    end else begin
      pend <= cand;
    end
  end
endmodule

// File: rtl/port_reset_status.sv
module port_reset_status
  import prs_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int PID_W  = $clog2(N_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [31:0]        wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [31:0]        rd_data,
  output logic [N_PORTS-1:0] slot_rst_req,
  output logic               evt_valid,
  input  logic               evt_ready,
  output logic [PID_W-1:0]   evt_port
);
  logic [N_PORTS-1:0] hit_vec;

  prs_reg_bank #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .hit_vec(hit_vec),
    .slot_rst_req(slot_rst_req)
  );

  prs_evt_arb #(.N_PORTS(N_PORTS), .IDX_W(IDX_W), .PID_W(PID_W)) u_arb (
    .clk(clk), .rst(rst), .set_vec(hit_vec), .evt_ready(evt_ready),
    .evt_valid(evt_valid), .evt_port(evt_port)
  );
endmodule

// File: rtl/port_reset_status_chk.sv
module port_reset_status_chk #(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2,
  parameter int PID_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [31:0]        wr_data,
  input logic [N_PORTS-1:0] slot_rst_req,
  input logic               evt_valid,
  input logic               evt_ready,
  input logic [PID_W-1:0]   evt_port
);
  localparam logic [N_PORTS-1:0] ONE = N_PORTS'(1);

  a_r5_req_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_rst_req));

  a_r5_req_after_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[4] || wr_data[31])) |=> (slot_rst_req == (ONE << $past(wr_idx))));

  a_r5_no_spurious_req: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_data[4] || wr_data[31])) |=> (slot_rst_req == '0));

  a_r6_port_range: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_port != '0) && (evt_port <= PID_W'(N_PORTS)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_port)));
endmodule

bind port_reset_status port_reset_status_chk #(
  .N_PORTS(N_PORTS), .IDX_W(IDX_W), .PID_W(PID_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .slot_rst_req(slot_rst_req), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_port(evt_port)
);

// File: tb/tb_port_reset_status.sv
module tb_port_reset_status;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  slot_rst_req;
  logic          evt_valid;
  logic          evt_ready = 1'b1;
  logic [PW-1:0] evt_port;

  port_reset_status #(.N_PORTS(N)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .slot_rst_req(slot_rst_req),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_port(evt_port)
  );

  always #5 clk = ~clk;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_bank [N];
  int          m_pend;
  bit          m_valid;
  int          m_port;
  int          m_slot;
  logic [31:0] m_rd;

  task automatic check(input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("rd_data", rd_data, m_rd);
    check("slot_rst_req", slot_rst_req, m_slot);
    check("evt_valid", evt_valid, m_valid);
    if (m_valid) check("evt_port", evt_port, m_port);
  endtask

  // advance model by one rising edge using currently driven inputs
  task automatic model_edge();
    int setv;
    bit rq;
    logic [31:0] v;
    if (rst) begin
      for (int i = 0; i < N; i++) m_bank[i] = '0;
      m_pend = 0; m_valid = 0; m_port = 0; m_slot = 0; m_rd = '0;
      return;
    end
    m_rd = m_bank[rd_idx];
    rq = wr_en && (wr_data[4] || wr_data[31]);
    setv = rq ? (1 << wr_idx) : 0;
    m_slot = setv;
    if (wr_en) begin
      v = wr_data;
      if (rq) begin
        v[8:5] = 4'h0; v[4] = 1'b0; v[1] = 1'b1; v[21] = 1'b1;
      end
      m_bank[wr_idx] = v;
    end
    m_pend = m_pend | setv;
    if (!m_valid || evt_ready) begin
      m_valid = 0;
      for (int i = 0; i < N; i++) begin
        if (!m_valid && ((m_pend >> i) & 1)) begin
          m_valid = 1;
          m_port = i + 1;
          m_pend = m_pend & ~(1 << i);
        end
      end
    end
  endtask

  task automatic cyc(input bit we, input int wi, input logic [31:0] wd,
                     input int ri, input bit rdy);
    wr_en = we; wr_idx = IW'(wi); wr_data = wd; rd_idx = IW'(ri); evt_ready = rdy;
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst = 1'b1;
    model_edge();
    repeat (3) begin @(negedge clk); compare(); end
    rst = 1'b0;
    // R1: idle after reset, read every register
    tag = "R1";
    for (int i = 0; i < N; i++) cyc(0, 0, 0, i, 1);
    // R2: plain writes stored verbatim, R10 registered read
    tag = "R2";
    cyc(1, 2, 32'h0012_3408, 2, 1);
    cyc(0, 0, 0, 2, 1);
    cyc(1, 0, 32'h7FFF_FFEF, 0, 1);
    cyc(0, 0, 0, 0, 1);
    tag = "R10";
    cyc(1, 1, 32'h0000_0C00, 1, 1);
    cyc(0, 0, 0, 1, 1);
    // R3 R4 R5 R6: normal reset on port 1
    tag = "R4";
    cyc(1, 1, 32'h0000_01F0, 1, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 1);
    // R3: warm reset only, bit 31 kept
    tag = "R3";
    cyc(1, 3, 32'h8000_0100, 3, 1);
    cyc(0, 0, 0, 3, 1);
    cyc(1, 0, 32'h8000_0010, 0, 1);
    cyc(0, 0, 0, 0, 1);
    // R5 R6: every port index
    tag = "R6";
    for (int i = 0; i < N; i++) begin
      cyc(1, i, 32'h0000_0010, i, 1);
      cyc(0, 0, 0, i, 1);
    end
    // R7 R8: back pressure, issue order lowest first
    tag = "R8";
    cyc(1, 3, 32'h0000_0010, 0, 0);
    cyc(1, 2, 32'h0000_0010, 0, 0);
    cyc(1, 0, 32'h0000_0010, 0, 0);
    tag = "R7";
    repeat (3) cyc(0, 0, 0, 0, 0);
    // R9: repeat of pending ports merges
    tag = "R9";
    cyc(1, 0, 32'h8000_0000, 0, 0);
    cyc(1, 2, 32'h0000_0010, 2, 0);
    cyc(1, 3, 32'h0000_0010, 3, 0);
    tag = "R8";
    repeat (6) cyc(0, 0, 0, 0, 1);
    // R7: alternating ready
    tag = "R7";
    cyc(1, 1, 32'h0000_0010, 1, 0);
    cyc(1, 2, 32'h0000_0010, 1, 1);
    cyc(0, 0, 0, 2, 0);
    cyc(0, 0, 0, 2, 1);
    repeat (3) cyc(0, 0, 0, 3, 1);
    // R1: reset mid-run clears everything
    tag = "R1";
    cyc(1, 2, 32'h0000_0010, 2, 0);
    rst = 1'b1;
    model_edge();
    @(negedge clk); compare();
    rst = 1'b0;
    for (int i = 0; i < N; i++) cyc(0, 0, 0, i, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule